// File: doc/BRIEF.md
# Effective Address Generator

This block sits between instruction decode and the data memory port of a small processor core. Given the addressing-mode code of a load or arithmetic-with-memory instruction, it produces the operand location. Its inputs are two register values (a base and an index), the program counter, a short signed offset, the instruction's 16-bit constant and the scale and step selectors. In register and immediate modes the result is the operand value itself and no memory access is wanted. A flag tells which case applies.

Auto-update modes also return the updated base register value and a write-back enable, for the register file to store. Memory-indirect mode takes two steps. The block first requests a pointer read at the instruction constant and holds off new work. It then presents the returned pointer as the effective address one cycle after the memory hands it back. All other legal modes resolve combinationally in the cycle the instruction is offered. Codes with no assigned mode are flagged illegal and produce nothing else.

Top module: `ea_gen_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `ea_valid_o`, `ptr_req_o`, `wb_en_o` and `busy_o` are low.
- R2: Mode 0 (register) returns `base_i` and mode 1 (immediate) returns `const_i`. Both raise `no_mem_o`, and only mode 1 raises `imm_flag_o`.
- R3: Mode 2 returns base plus offset, mode 3 returns base, mode 4 returns base plus index and mode 5 returns base plus index plus offset. The 8-bit offset is sign-extended and all sums wrap modulo 2^16.
- R4: Mode 6 (direct) returns `const_i` as a memory address, with `no_mem_o` low.
- R5: Mode 8 (post-increment) returns base as the address, raises `wb_en_o` and gives base plus step on `wb_val_o`. `step_sel_i` values 0,1,2,3 select steps 1,2,4,8. `wb_en_o` is high only for modes 8 and 9 with an instruction offered.
- R6: Mode 9 (pre-decrement) gives base minus step on `wb_val_o` and returns that same new value as the address.
- R7: Mode 10 (scaled) returns base plus index times 1,2,4 or 8, selected by `scale_sel_i` values 0 to 3, with wrap.
- R8: Mode 11 (PC-relative) returns program counter plus base plus sign-extended offset.
- R9: Mode 7 (memory indirect) raises `ptr_req_o` for exactly one cycle, with `ptr_addr_o` equal to `const_i`, and raises `busy_o`. The cycle after `ptr_valid_i` is seen high, `ea_valid_o` is high and `ea_o` equals the word returned on `ptr_data_i`.
- R10: While `busy_o` is high and before the pointer result is shown, an offered instruction is ignored: no valid, request or write-back is produced.
- R11: Mode codes 12 to 15 raise `illegal_o` and keep `ea_valid_o`, `wb_en_o`, `ptr_req_o` and `no_mem_o` low.
- R12: Every legal mode other than 7 raises `ea_valid_o` in the same cycle `op_valid_i` is high and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | An instruction is offered this cycle |
| mode_i | input | 4 | Addressing-mode code |
| base_i | input | 16 | Base register value |
| index_i | input | 16 | Index register value |
| pc_i | input | 16 | Program counter |
| disp_i | input | 8 | Signed offset |
| const_i | input | 16 | Instruction constant (immediate or absolute address) |
| scale_sel_i | input | 2 | Index scale selector |
| step_sel_i | input | 2 | Auto-update step selector |
| ptr_valid_i | input | 1 | Pointer word returned by memory |
| ptr_data_i | input | 16 | Returned pointer word |
| ea_o | output | 16 | Effective address or operand value |
| ea_valid_o | output | 1 | `ea_o` is valid |
| imm_flag_o | output | 1 | `ea_o` is the immediate constant |
| no_mem_o | output | 1 | `ea_o` is an operand value, no memory access |
| wb_en_o | output | 1 | Base register write-back enable |
| wb_val_o | output | 16 | Updated base register value |
| ptr_req_o | output | 1 | Pointer read request |
| ptr_addr_o | output | 16 | Pointer read address |
| busy_o | output | 1 | Indirect access in progress |
| illegal_o | output | 1 | Unassigned mode code offered |

## Verification
The assertions assume that `mode_i` and the operand inputs stay steady through any cycle in which `op_valid_i` is sampled. They also assume that `ptr_valid_i` rises only while a pointer read is outstanding. The bench changes inputs only at falling clock edges. It raises `ptr_valid_i` only after it has seen `ptr_req_o`, and for one cycle. It offers an instruction during the wait only to test that the instruction is dropped.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    MD_REG  = 4'd0,
    MD_IMM  = 4'd1,
    MD_DISP = 4'd2,
    MD_RIND = 4'd3,
    MD_IDX  = 4'd4,
    MD_IDXD = 4'd5,
    MD_DIR  = 4'd6,
    MD_MIND = 4'd7,
    MD_AINC = 4'd8,
    MD_ADEC = 4'd9,
    MD_SCL  = 4'd10,
    MD_PCR  = 4'd11
  } ea_mode_e;

  localparam int unsigned MODE_COUNT = 12;

  function automatic logic mode_legal(input logic [3:0] m);
    return 32'(m) < MODE_COUNT;
  endfunction
endpackage

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
  import ea_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [3:0]    mode,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] index,
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] disp,
  input  logic [AW-1:0] cst,
  input  logic [1:0]    scale_sel,
  input  logic [1:0]    step_sel,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] wb_val,
  output logic          wb_use,
  output logic          no_mem,
  output logic          imm,
  output logic          legal,
  output logic          indirect
);
  localparam int EXT = AW - DW;

  function automatic logic [AW-1:0] sext(input logic [DW-1:0] d);
    return {{EXT{d[DW-1]}}, d};
  endfunction

  function automatic logic [AW-1:0] pow2(input logic [1:0] sel);
    return AW'(1) << sel;
  endfunction

  function automatic logic [AW-1:0] scaled(input logic [AW-1:0] b,
                                           input logic [AW-1:0] i,
                                           input logic [1:0]    sel);
    return b + (i << sel);
  endfunction

  logic [AW-1:0] off;
  logic [AW-1:0] step;

  assign off   = sext(disp);
  assign step  = pow2(step_sel);
  assign legal = mode_legal(mode);

  always_comb begin
    ea       = base;
    wb_val   = base;
    wb_use   = 1'b0;
    no_mem   = 1'b0;
    imm      = 1'b0;
    indirect = 1'b0;
    case (mode)
      MD_REG:  no_mem = 1'b1;
      MD_IMM:  begin ea = cst; no_mem = 1'b1; imm = 1'b1; end
      MD_DISP: ea = base + off;
      MD_RIND: ea = base;
      MD_IDX:  ea = base + index;
      MD_IDXD: ea = base + index + off;
      MD_DIR:  ea = cst;
      MD_MIND: begin ea = cst; indirect = 1'b1; end
      MD_AINC: begin ea = base; wb_val = base + step; wb_use = 1'b1; end
      MD_ADEC: begin wb_val = base - step; ea = base - step; wb_use = 1'b1; end
      MD_SCL:  ea = scaled(base, index, scale_sel);
      MD_PCR:  ea = pc + base + off;
      default: ea = '0;
    endcase
  end
endmodule

// File: rtl/ea_indirect_seq.sv
module ea_indirect_seq #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ptr_valid,
  input  logic [AW-1:0] ptr_data,
  output logic          idle,
  output logic          wait_st,
  output logic          done_st,
  output logic [AW-1:0] ptr_q
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DONE} seq_e;
  seq_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ptr_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) st <= S_WAIT;
        S_WAIT: if (ptr_valid) begin
          st    <= S_DONE;
          ptr_q <= ptr_data;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign idle    = (st == S_IDLE);
  assign wait_st = (st == S_WAIT);
  assign done_st = (st == S_DONE);
endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid_i,
  input  logic [3:0]    mode_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] index_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] disp_i,
  input  logic [AW-1:0] const_i,
  input  logic [1:0]    scale_sel_i,
  input  logic [1:0]    step_sel_i,
  input  logic          ptr_valid_i,
  input  logic [AW-1:0] ptr_data_i,
  output logic [AW-1:0] ea_o,
  output logic          ea_valid_o,
  output logic          imm_flag_o,
  output logic          no_mem_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_val_o,
  output logic          ptr_req_o,
  output logic [AW-1:0] ptr_addr_o,
  output logic          busy_o,
  output logic          illegal_o
);
  logic [AW-1:0] calc_ea, calc_wb, ptr_q;
  logic calc_wb_use, calc_no_mem, calc_imm, calc_legal, calc_ind;
  logic seq_idle, ind_wait, ind_done, accept, ind_start;

  ea_addr_calc #(.AW(AW), .DW(DW)) u_calc (
    .mode(mode_i), .base(base_i), .index(index_i), .pc(pc_i),
    .disp(disp_i), .cst(const_i), .scale_sel(scale_sel_i),
    .step_sel(step_sel_i), .ea(calc_ea), .wb_val(calc_wb),
    .wb_use(calc_wb_use), .no_mem(calc_no_mem), .imm(calc_imm),
    .legal(calc_legal), .indirect(calc_ind)
  );

  assign accept    = op_valid_i && seq_idle;
  assign ind_start = accept && calc_legal && calc_ind;

  ea_indirect_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(ind_start),
    .ptr_valid(ptr_valid_i), .ptr_data(ptr_data_i),
    .idle(seq_idle), .wait_st(ind_wait), .done_st(ind_done), .ptr_q(ptr_q)
  );

  assign ea_o       = ind_done ? ptr_q : calc_ea;
  assign ea_valid_o = (accept && calc_legal && !calc_ind) || ind_done;
  assign imm_flag_o = accept && calc_legal && calc_imm;
  assign no_mem_o   = accept && calc_legal && calc_no_mem;
  assign wb_en_o    = accept && calc_legal && calc_wb_use;
  assign wb_val_o   = calc_wb;
  assign ptr_req_o  = ind_start;
  assign ptr_addr_o = const_i;
  assign busy_o     = !seq_idle;
  assign illegal_o  = accept && !calc_legal;
endmodule

// File: rtl/ea_gen_unit_chk.sv
module ea_gen_unit_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    mode_i,
  input logic [AW-1:0] base_i,
  input logic [AW-1:0] const_i,
  input logic          ptr_valid_i,
  input logic [AW-1:0] ptr_data_i,
  input logic [AW-1:0] ea_o,
  input logic          ea_valid_o,
  input logic          imm_flag_o,
  input logic          no_mem_o,
  input logic          wb_en_o,
  input logic [AW-1:0] wb_val_o,
  input logic          ptr_req_o,
  input logic          busy_o,
  input logic          illegal_o,
  input logic          ind_wait,
  input logic          ind_done
);
  AST_IMM_IS_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    imm_flag_o |-> (no_mem_o && ea_o == const_i)); // R2
  AST_WB_ONLY_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |-> (ea_valid_o && (mode_i == 4'd8 || mode_i == 4'd9))); // R5
  AST_POSTINC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en_o && mode_i == 4'd8) |-> (ea_o == base_i && wb_val_o != base_i)); // R5
  AST_PREDEC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en_o && mode_i == 4'd9) |-> (ea_o == wb_val_o && wb_val_o != base_i)); // R6
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_req_o |=> (!ptr_req_o && busy_o)); // R9
  AST_PTR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_wait && ptr_valid_i) |=> (ea_valid_o && ea_o == $past(ptr_data_i))); // R9
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !ind_done) |-> (!ea_valid_o && !ptr_req_o && !wb_en_o)); // R10
  AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!ea_valid_o && !wb_en_o && !ptr_req_o && !no_mem_o)); // R11
endmodule

bind ea_gen_unit ea_gen_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .base_i(base_i),
  .const_i(const_i), .ptr_valid_i(ptr_valid_i), .ptr_data_i(ptr_data_i),
  .ea_o(ea_o), .ea_valid_o(ea_valid_o), .imm_flag_o(imm_flag_o),
  .no_mem_o(no_mem_o), .wb_en_o(wb_en_o), .wb_val_o(wb_val_o),
  .ptr_req_o(ptr_req_o), .busy_o(busy_o), .illegal_o(illegal_o),
  .ind_wait(ind_wait), .ind_done(ind_done)
);

// File: tb/ea_gen_unit_test.sv
module ea_gen_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid_i = 1'b0;
  logic [3:0] mode_i = '0;
  logic [15:0] base_i = '0, index_i = '0, pc_i = '0, const_i = '0, ptr_data_i = '0;
  logic [7:0] disp_i = '0;
  logic [1:0] scale_sel_i = '0, step_sel_i = '0;
  logic ptr_valid_i = 1'b0;
  logic [15:0] ea_o, wb_val_o, ptr_addr_o;
  logic ea_valid_o, imm_flag_o, no_mem_o, wb_en_o, ptr_req_o, busy_o, illegal_o;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ea_gen_unit uut (.*);

  typedef struct packed {
    logic [3:0]  md;
    logic [15:0] ra, rb, pc;
    logic [7:0]  dp;
    logic [15:0] cs;
    logic [1:0]  ss, ds;
    logic [15:0] ea;
    logic        wen;
    logic [15:0] wb;
    logic        imm, nm;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{4'd0,  16'h1234, 16'h0000, 16'h0000, 8'h00, 16'h0000, 2'd0, 2'd0, 16'h1234, 1'b0, 16'h0000, 1'b0, 1'b1, 4'd2},  // R2
    '{4'd1,  16'h0000, 16'h0000, 16'h0000, 8'h00, 16'hBEEF, 2'd0, 2'd0, 16'hBEEF, 1'b0, 16'h0000, 1'b1, 1'b1, 4'd2},  // R2
    '{4'd2,  16'h1000, 16'h0000, 16'h0000, 8'hF0, 16'h0000, 2'd0, 2'd0, 16'h0FF0, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd3},  // R3
    '{4'd2,  16'hFFFF, 16'h0000, 16'h0000, 8'h02, 16'h0000, 2'd0, 2'd0, 16'h0001, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd3},  // R3
    '{4'd3,  16'h4321, 16'h9999, 16'h0000, 8'h33, 16'h0000, 2'd0, 2'd0, 16'h4321, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd3},  // R3
    '{4'd4,  16'h1000, 16'h0234, 16'h0000, 8'h00, 16'h0000, 2'd0, 2'd0, 16'h1234, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd3},  // R3
    '{4'd5,  16'h1000, 16'h0200, 16'h0000, 8'h80, 16'h0000, 2'd0, 2'd0, 16'h1180, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd3},  // R3
    '{4'd6,  16'h7777, 16'h0000, 16'h0000, 8'h00, 16'h00A0, 2'd0, 2'd0, 16'h00A0, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd4},  // R4
    '{4'd8,  16'h2000, 16'h0000, 16'h0000, 8'h00, 16'h0000, 2'd0, 2'd2, 16'h2000, 1'b1, 16'h2004, 1'b0, 1'b0, 4'd5},  // R5
    '{4'd8,  16'hFFFF, 16'h0000, 16'h0000, 8'h00, 16'h0000, 2'd0, 2'd0, 16'hFFFF, 1'b1, 16'h0000, 1'b0, 1'b0, 4'd5},  // R5
    '{4'd9,  16'h2000, 16'h0000, 16'h0000, 8'h00, 16'h0000, 2'd0, 2'd3, 16'h1FF8, 1'b1, 16'h1FF8, 1'b0, 1'b0, 4'd6},  // R6
    '{4'd9,  16'h0000, 16'h0000, 16'h0000, 8'h00, 16'h0000, 2'd0, 2'd1, 16'hFFFE, 1'b1, 16'hFFFE, 1'b0, 1'b0, 4'd6},  // R6
    '{4'd10, 16'h0100, 16'h0003, 16'h0000, 8'h00, 16'h0000, 2'd3, 2'd0, 16'h0118, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd7},  // R7
    '{4'd10, 16'h0100, 16'h0003, 16'h0000, 8'h00, 16'h0000, 2'd0, 2'd0, 16'h0103, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd7},  // R7
    '{4'd10, 16'h0100, 16'h8001, 16'h0000, 8'h00, 16'h0000, 2'd1, 2'd0, 16'h0102, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd7},  // R7
    '{4'd11, 16'h0010, 16'h0000, 16'h0040, 8'hFC, 16'h0000, 2'd0, 2'd0, 16'h004C, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd8}   // R8
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(20 * 5000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: outputs quiet under reset
    repeat (2) @(negedge clk);
    #5 chk(!ea_valid_o && !ptr_req_o && !wb_en_o && !busy_o, "R1 in reset",
           {ea_valid_o, ptr_req_o, wb_en_o, busy_o}, 0);
    @(negedge clk) rst_n = 1'b1;
    #5 chk(!ea_valid_o && !ptr_req_o && !wb_en_o && !busy_o, "R1 after reset",
           {ea_valid_o, ptr_req_o, wb_en_o, busy_o}, 0);

    // Table walk: R12 same-cycle valid for every legal non-indirect mode
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      op_valid_i = 1'b1; mode_i = TBL[k].md; base_i = TBL[k].ra; index_i = TBL[k].rb;
      pc_i = TBL[k].pc; disp_i = TBL[k].dp; const_i = TBL[k].cs;
      scale_sel_i = TBL[k].ss; step_sel_i = TBL[k].ds;
      #5;
      chk(ea_valid_o && !ptr_req_o && !illegal_o && ea_o == TBL[k].ea &&
          wb_en_o == TBL[k].wen && (!TBL[k].wen || wb_val_o == TBL[k].wb) &&
          imm_flag_o == TBL[k].imm && no_mem_o == TBL[k].nm,
          $sformatf("R%0d/R12 row %0d", TBL[k].rq, k),
          {ea_o, wb_val_o}, {TBL[k].ea, TBL[k].wb});
    end

    // R5: auto-update mode not offered -> no write-back
    @(negedge clk);
    op_valid_i = 1'b0; mode_i = 4'd8; base_i = 16'h3000;
    #5 chk(!wb_en_o && !ea_valid_o, "R5 idle no writeback", {wb_en_o, ea_valid_o}, 0);

    // R11: illegal codes
    @(negedge clk);
    op_valid_i = 1'b1; mode_i = 4'd12;
    #5 chk(illegal_o && !ea_valid_o && !wb_en_o && !ptr_req_o && !no_mem_o, "R11 code 12",
           {illegal_o, ea_valid_o, wb_en_o, ptr_req_o, no_mem_o}, 5'b10000);
    @(negedge clk);
    mode_i = 4'd15;
    #5 chk(illegal_o && !ea_valid_o && !wb_en_o && !ptr_req_o && !no_mem_o, "R11 code 15",
           {illegal_o, ea_valid_o, wb_en_o, ptr_req_o, no_mem_o}, 5'b10000);

    // R9: memory indirect
    @(negedge clk);
    mode_i = 4'd7; const_i = 16'h0050;
    #5 chk(ptr_req_o && ptr_addr_o == 16'h0050 && !ea_valid_o, "R9 request",
           {ptr_req_o, ptr_addr_o}, {1'b1, 16'h0050});
    // R10: instruction offered while waiting is dropped
    @(negedge clk);
    mode_i = 4'd8; base_i = 16'h0AAA;
    #5 chk(busy_o && !ptr_req_o && !ea_valid_o && !wb_en_o, "R9/R10 waiting",
           {busy_o, ptr_req_o, ea_valid_o, wb_en_o}, 4'b1000);
    @(negedge clk);
    op_valid_i = 1'b0; ptr_valid_i = 1'b1; ptr_data_i = 16'hABCD;
    #5 chk(!ea_valid_o, "R9 not yet valid", ea_valid_o, 0);
    @(negedge clk);
    ptr_valid_i = 1'b0; ptr_data_i = 16'h0000;
    #5 chk(ea_valid_o && ea_o == 16'hABCD && !ptr_req_o, "R9 pointer result",
           ea_o, 16'hABCD);
    @(negedge clk);
    #5 chk(!busy_o && !ea_valid_o, "R9 back to idle", {busy_o, ea_valid_o}, 0);

    // R12: new instruction accepted right after indirect
    @(negedge clk);
    op_valid_i = 1'b1; mode_i = 4'd4; base_i = 16'h0001; index_i = 16'hFFFF;
    #5 chk(ea_valid_o && ea_o == 16'h0000, "R3/R12 after indirect", ea_o, 16'h0000);

    @(negedge clk) op_valid_i = 1'b0;
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule